// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller latches interrupt events from `NUM_SRC` sources into per-source pending flags. Each flag is gated by its own enable bit and by one global enable. While any gated flag is pending, a request level goes to the CPU. When the CPU acknowledges, the controller does four things in one edge:

- It picks the pending source with the lowest index. This is the one with the lowest vector address, so it has the highest priority.
- It registers that source's vector address.
- It clears that source's flag.
- It drops the global enable so that nothing else can interrupt.

A return strobe from the CPU turns the global enable back on. Software can also turn it on from inside a handler, which allows nesting.

Vector index 0 belongs to reset. Source `i` uses index `i+1`, and each entry is two words apart. The vector is therefore `base + 2*(i+1)`. A control bit selects the base: either 0 or the parameter `BOOT_BASE`.

Software uses a small write port with three registers:

- a write-one-to-clear flag register;
- an enable register;
- a control register holding the global enable and the table select.

The state is visible on plain output ports.

Top module: `vpic_top`

## Requirements
- R1: A high bit on `evtIn[i]` at a clock edge sets flag `i` after that edge. This happens whatever the state of the enables. The flag stays set until it is serviced or cleared by software.
- R2: `irqReq` is high exactly when the global enable is 1 and at least one flag is set whose enable bit is also 1.
- R3: When several enabled flags are pending, the lowest source index wins. Its vector is `base + 2*(i+1)`, because index 0 is reserved for reset.
- R4: An `irqAck` while `irqReq` is high has three effects after that edge: the global enable becomes 0, `vecAddr` holds the winner's vector, and the winner's flag is cleared.
- R5: An `irqAck` while `irqReq` is low changes no flag, no global enable and no `vecAddr`.
- R6: `retStb` sets the global enable to 1 after the edge. If an acknowledge is taken in the same cycle, the global enable ends at 0.
- R7: A write with `wrSel`=2 loads the global enable from `wrData[0]` and the table select from `wrData[1]`. Setting the enable inside a handler lets pending sources nest.
- R8: A write with `wrSel`=0 clears every flag whose `wrData` bit is 1. Bits written as 0 have no effect. An event on the same flag in the same cycle keeps the flag set.
- R9: A write with `wrSel`=1 loads the per-source enable bits from `wrData`.
- R10: With the table select at 1 the base is `BOOT_BASE`; with it at 0 the base is 0.
- R11: Reset clears all flags, enables, the global enable, the table select and `vecAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_SRC | Per-source event, sampled each edge |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 flag clear, 1 enables, 2 control |
| wrData | input | NUM_SRC | Write data |
| irqAck | input | 1 | CPU acknowledge, one cycle |
| retStb | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Interrupt request level |
| vecAddr | output | ADDR_W | Vector of the last taken interrupt |
| flagOut | output | NUM_SRC | Pending flags |
| enableOut | output | NUM_SRC | Per-source enables |
| gieOut | output | 1 | Global enable |
| vecSelOut | output | 1 | Table select |

## Verification
Flags, enables, the global enable, the table select and `vecAddr` are all registers. Each of them shows the effect of a stimulus one clock edge after that stimulus is driven. `irqReq` is a combinational function of that registered state, so it is valid in the same cycle as the new state.

The bench drives every stimulus on a falling edge and samples all outputs on the following falling edge. Every expected value is therefore checked exactly one rising edge after the stimulus that causes it, and never against a value that is still changing. The collision cases are each given their own vector:

- an event arriving together with an acknowledge;
- an event arriving together with a clear;
- a return strobe arriving together with an acknowledge.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  // Register select codes on the write port
  localparam logic [1:0] SEL_FLAGS = 2'd0;
  localparam logic [1:0] SEL_EN    = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  // Control register bit positions
  localparam int CTRL_GIE_BIT  = 0;
  localparam int CTRL_VSEL_BIT = 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;     // acknowledge accepted this cycle
    logic restore;  // return-from-interrupt seen
  } ctlStrobe_t;
endpackage

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pending,
  input  logic               gie,
  input  logic               irqAck,
  input  logic               retStb,
  output logic               irqReq,
  output logic [IDX_W-1:0]   winIdx,
  output ctlStrobe_t         strobe
);
  // Lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) winIdx = IDX_W'(i);
    end
  end

  assign irqReq         = gie && (|pending);
  assign strobe.take    = irqAck && irqReq;
  assign strobe.restore = retStb;

  // R3: the chosen source is pending and nothing below it is
  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> (pending[winIdx] &&
      ((pending & ((NUM_SRC'(1) << winIdx) - NUM_SRC'(1))) == '0)));
endmodule

// File: rtl/vpic_dp.sv
module vpic_dp
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 16,
  parameter int unsigned BOOT_BASE = 'hF000,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [NUM_SRC-1:0] wrData,
  input  ctlStrobe_t         strobe,
  input  logic [IDX_W-1:0]   winIdx,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic               gieQ,
  output logic               vselQ,
  output logic [ADDR_W-1:0]  vecQ
);
  localparam logic [ADDR_W-1:0] BASE_ALT = ADDR_W'(BOOT_BASE);

  logic wrFlags, wrEnReg, wrCtrl;
  logic [NUM_SRC-1:0] flagD;
  logic [ADDR_W-1:0]  vecD;

  assign wrFlags = wrEn && (wrSel == SEL_FLAGS);
  assign wrEnReg = wrEn && (wrSel == SEL_EN);
  assign wrCtrl  = wrEn && (wrSel == SEL_CTRL);

  // Per-flag next state: clears first, event set wins last
  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    always_comb begin
      flagD[g] = flagQ[g];
      if (wrFlags && wrData[g]) flagD[g] = 1'b0;
      if (strobe.take && (winIdx == IDX_W'(g))) flagD[g] = 1'b0;
      if (evtIn[g]) flagD[g] = 1'b1;
    end
  end

  // Entry index is source + 1 (reset owns index 0), entries 2 words apart
  always_comb begin
    vecD = (vselQ ? BASE_ALT : '0) + ((ADDR_W'(winIdx) + ADDR_W'(1)) << 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      gieQ  <= 1'b0;
      vselQ <= 1'b0;
      vecQ  <= '0;
    end else begin
      flagQ <= flagD;
      if (wrEnReg) enQ <= wrData;
      if (wrCtrl) vselQ <= wrData[CTRL_VSEL_BIT];
      if (strobe.take) begin
        gieQ <= 1'b0;
        vecQ <= vecD;
      end else if (wrCtrl) begin
        gieQ <= wrData[CTRL_GIE_BIT];
      end else if (strobe.restore) begin
        gieQ <= 1'b1;
      end
    end
  end

  // R1: an event always leaves its flag set
  a_r1_event_latched: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((flagQ & $past(evtIn)) == $past(evtIn)));
  // R4: entry masks further interrupts
  a_r4_entry_masks: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> !gieQ);
  // R4: serviced flag is cleared unless re-raised
  a_r4_flag_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !evtIn[winIdx]) |=> !flagQ[$past(winIdx)]);
  // R6: return restores the global enable
  a_r6_return_sets: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.restore && !strobe.take && !wrCtrl) |=> gieQ);
  // R8: written ones clear flags that saw no event
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrFlags |=> ((flagQ & $past(wrData & ~evtIn)) == '0));
  // R5: no take means vector holds
  a_r5_vec_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> $stable(vecQ));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 16,
  parameter int unsigned BOOT_BASE = 'hF000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               irqAck,
  input  logic               retStb,
  output logic               irqReq,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [NUM_SRC-1:0] flagOut,
  output logic [NUM_SRC-1:0] enableOut,
  output logic               gieOut,
  output logic               vecSelOut
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] winIdx;
  logic [NUM_SRC-1:0] pending;

  assign pending = flagOut & enableOut;

  vpic_ctrl #(.NUM_SRC(NUM_SRC)) ctrl_i (
    .clk(clk), .rstN(rstN), .pending(pending), .gie(gieOut),
    .irqAck(irqAck), .retStb(retStb), .irqReq(irqReq),
    .winIdx(winIdx), .strobe(strobe)
  );

  vpic_dp #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) dp_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .strobe(strobe), .winIdx(winIdx), .flagQ(flagOut),
    .enQ(enableOut), .gieQ(gieOut), .vselQ(vecSelOut), .vecQ(vecAddr)
  );
endmodule

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;
  localparam int NS = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] evtIn = '0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [NS-1:0] wrData = '0;
  logic irqAck = 1'b0;
  logic retStb = 1'b0;
  logic irqReq;
  logic [AW-1:0] vecAddr;
  logic [NS-1:0] flagOut, enableOut;
  logic gieOut, vecSelOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  vpic_top #(.NUM_SRC(NS), .ADDR_W(AW), .BOOT_BASE('hF000)) dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .irqAck(irqAck), .retStb(retStb), .irqReq(irqReq),
    .vecAddr(vecAddr), .flagOut(flagOut), .enableOut(enableOut),
    .gieOut(gieOut), .vecSelOut(vecSelOut)
  );

  typedef struct packed {
    logic [7:0]  evt;
    logic        wr;
    logic [1:0]  sel;
    logic [7:0]  data;
    logic        ack;
    logic        ret;
    logic [7:0]  eFlags;
    logic        eGie;
    logic        eReq;
    logic [15:0] eVec;
    logic [7:0]  req;
  } step_t;

  localparam int NSTEP = 24;
  localparam step_t STEPS [NSTEP] = '{
    '{8'h05,0,2'd0,8'h00,0,0, 8'h05,0,0,16'h0000, 8'd1},  // R1 masked events latch
    '{8'h00,1,2'd1,8'h0F,0,0, 8'h05,0,0,16'h0000, 8'd9},  // R9 enables
    '{8'h00,1,2'd2,8'h01,0,0, 8'h05,1,1,16'h0000, 8'd2},  // R2 request rises
    '{8'h00,0,2'd0,8'h00,1,0, 8'h04,0,0,16'h0002, 8'd4},  // R4 source 0 taken
    '{8'h00,0,2'd0,8'h00,0,1, 8'h04,1,1,16'h0002, 8'd6},  // R6 return
    '{8'h00,0,2'd0,8'h00,1,0, 8'h00,0,0,16'h0006, 8'd3},  // R3 source 2
    '{8'h30,0,2'd0,8'h00,0,0, 8'h30,0,0,16'h0006, 8'd1},  // R1
    '{8'h00,1,2'd2,8'h03,0,0, 8'h30,1,0,16'h0006, 8'd2},  // R2 masked by enables
    '{8'h00,1,2'd1,8'hFF,0,0, 8'h30,1,1,16'h0006, 8'd9},  // R9
    '{8'h00,0,2'd0,8'h00,1,0, 8'h20,0,0,16'hF00A, 8'd10}, // R10 boot base
    '{8'h00,1,2'd2,8'h03,0,0, 8'h20,1,1,16'hF00A, 8'd7},  // R7 nesting
    '{8'h01,0,2'd0,8'h00,1,0, 8'h01,0,0,16'hF00C, 8'd4},  // R4 event with ack
    '{8'h01,1,2'd0,8'h01,0,0, 8'h01,0,0,16'hF00C, 8'd8},  // R8 set beats clear
    '{8'h00,1,2'd0,8'h01,0,0, 8'h00,0,0,16'hF00C, 8'd8},  // R8 clear
    '{8'h00,0,2'd0,8'h00,1,0, 8'h00,0,0,16'hF00C, 8'd5},  // R5 ack ignored
    '{8'h80,0,2'd0,8'h00,0,1, 8'h80,1,1,16'hF00C, 8'd6},  // R6
    '{8'h02,0,2'd0,8'h00,0,0, 8'h82,1,1,16'hF00C, 8'd1},  // R1
    '{8'h00,0,2'd0,8'h00,1,0, 8'h80,0,0,16'hF004, 8'd3},  // R3 source 1 over 7
    '{8'h00,1,2'd0,8'h00,0,0, 8'h80,0,0,16'hF004, 8'd8},  // R8 zeros no effect
    '{8'h00,1,2'd2,8'h01,0,0, 8'h80,1,1,16'hF004, 8'd10}, // R10 back to base 0
    '{8'h00,0,2'd0,8'h00,1,0, 8'h00,0,0,16'h0010, 8'd3},  // R3 last source
    '{8'h01,0,2'd0,8'h00,0,0, 8'h01,0,0,16'h0010, 8'd5},  // R5 no request
    '{8'h00,1,2'd2,8'h01,0,0, 8'h01,1,1,16'h0010, 8'd7},  // R7
    '{8'h00,0,2'd0,8'h00,1,1, 8'h00,0,0,16'h0002, 8'd6}   // R6 ack beats return
  };

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input int req, input logic [7:0] f, input logic g,
                          input logic r, input logic [15:0] v);
    check("flags", req, 32'(flagOut), 32'(f));
    check("gie", req, 32'(gieOut), 32'(g));
    check("irqReq", req, 32'(irqReq), 32'(r));
    check("vecAddr", req, 32'(vecAddr), 32'(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    checkAll(11, 8'h00, 1'b0, 1'b0, 16'h0000);
    check("enables", 11, 32'(enableOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int s = 0; s < NSTEP; s++) begin
      evtIn  = STEPS[s].evt;
      wrEn   = STEPS[s].wr;
      wrSel  = STEPS[s].sel;
      wrData = STEPS[s].data;
      irqAck = STEPS[s].ack;
      retStb = STEPS[s].ret;
      @(negedge clk);
      evtIn = '0; wrEn = 1'b0; irqAck = 1'b0; retStb = 1'b0;
      checkAll(int'(STEPS[s].req), STEPS[s].eFlags, STEPS[s].eGie,
               STEPS[s].eReq, STEPS[s].eVec);
    end
    // R9 enables held, R10 select readback
    check("enables", 9, 32'(enableOut), 32'hFF);
    check("vsel", 10, 32'(vecSelOut), 0);
    // R11 reset mid-run with state loaded
    evtIn = 8'h40;
    @(negedge clk);
    evtIn = '0;
    rstN = 1'b0;
    @(negedge clk);
    checkAll(11, 8'h00, 1'b0, 1'b0, 16'h0000);
    check("enables", 11, 32'(enableOut), 0);
    check("vsel", 11, 32'(vecSelOut), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule